// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the status flags of an asynchronous serial port: two receive error flags (framing and parity), a transmit-end flag, the multiprocessor bit of the most recent received frame, and a software-written multiprocessor bit for the next transmitted frame. The receiver and transmitter are separate blocks. They report events to this register as single-cycle pulses, and the register turns those pulses into sticky flags.

Software reads the register over a simple CPU bus with a read strobe and a write strobe. An error flag clears only under a read-then-write-zero rule. The CPU must first read the register while the flag is 1. Its next write to the register then clears the flag if the written bit is 0. Writing 1 never sets a flag. The transmit-end flag cannot be cleared by writing to it. It clears when the transmit-data-empty flag goes through its own read-then-clear sequence, reported here as a pulse, or when the DMA controller writes the transmit data register. A standby request acts on the flags the way reset does.

Each error flag runs its own three-state machine:
- `FL_CLEAR`: the flag is 0.
- `FL_SET_UNSEEN`: the flag is 1 and has not been read.
- `FL_SET_SEEN`: the flag is 1 and has been read as 1.

The transitions are:
- `FL_CLEAR` → `FL_SET_UNSEEN` on a set event.
- `FL_SET_UNSEEN` → `FL_SET_SEEN` on a read.
- `FL_SET_SEEN` → `FL_CLEAR` on a write of 0 to the flag's bit.
- `FL_SET_SEEN` → `FL_SET_UNSEEN` on a write of 1, which uses up the marker, or on a new set event.
- Any state → `FL_CLEAR` on standby.

The set event takes priority over both the write and the read. When a read and a write fall in the same cycle, the write is handled and the read latches no marker.

The transmit-end flag has two states, `TX_BUSY` and `TX_ENDED`:
- `TX_BUSY` → `TX_ENDED` on a set event.
- `TX_ENDED` → `TX_BUSY` on a clear event.
- Any state → `TX_ENDED` on standby.

A set event takes priority over a clear event in the same cycle.

Top module: `ser_stat_reg`

## Requirements
- R1: After reset, `rd_data` is 5'b00100 (bit 2 is transmit-end; bit 4, bit 3, bit 1 and bit 0 are the other flags, as in R2 to R12). Asserting `standby` for one cycle clears bits 4 and 3 and sets bit 2 on the next clock edge.
- R2: A pulse on `rx_frame_err` sets bit 4, the framing-error flag, on the next clock edge.
- R3: A pulse on `rx_parity_err` sets bit 3, the parity-error flag, on the next clock edge.
- R4: A write with a 0 in the bit of an error flag clears that flag on the next clock edge, provided that the flag was read as 1 by a `bus_rd` strobe after its last set event and before this write.
- R5: A write of 0 to an error flag that has not been read as 1 since it was set leaves the flag at 1. A write of 1 to bit 4 or bit 3 never sets that flag.
- R6: Any write uses up the read marker of every error flag. A later write of 0, without a new read, leaves the flag set.
- R7: A set event that arrives between the read and the write cancels the marker, so the write of 0 leaves the flag set.
- R8: If a set event and a qualifying write of 0 occur in the same cycle, the flag stays 1.
- R9: Bit 2 sets on a `tx_disable` pulse. It also sets on a `tx_last_bit` pulse while `tdr_empty` is 1. A `tx_last_bit` pulse while `tdr_empty` is 0 has no effect.
- R10: Bit 2 clears on a `tdre_clear` pulse or a `dma_tdr_wr` pulse. A set event in the same cycle wins.
- R11: On an `rx_done` pulse, bit 1 takes the value of `rx_mpb`.
- R12: Each write loads bit 0 from `bus_wdata[0]`, and bit 0 drives `tx_mpb`. Writes change neither bit 2 nor bit 1, whatever the data and whether or not the register was read first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| standby | input | 1 | Standby entry; clears the error flags and sets transmit-end |
| bus_rd | input | 1 | CPU read strobe for this register |
| bus_wr | input | 1 | CPU write strobe for this register |
| bus_wdata | input | 5 | CPU write data |
| rd_data | output | 5 | Register value: {framing, parity, tx end, rx mpb, tx mpb} |
| rx_frame_err | input | 1 | Receiver pulse: stop bit sampled as 0 |
| rx_parity_err | input | 1 | Receiver pulse: parity disagrees with odd/even setting |
| rx_done | input | 1 | Receiver pulse: frame complete |
| rx_mpb | input | 1 | Multiprocessor bit of the completing frame |
| tx_disable | input | 1 | Pulse: transmitter enable turned off |
| tx_last_bit | input | 1 | Pulse: last bit of a character sent |
| tdr_empty | input | 1 | Level of the transmit-data-empty flag |
| tdre_clear | input | 1 | Pulse: transmit-data-empty cleared by read-then-write-zero |
| dma_tdr_wr | input | 1 | Pulse: DMA write to the transmit data register |
| tx_mpb | output | 1 | Multiprocessor bit for the next transmitted frame |

## Verification
A wrong error-flag state shows at `rd_data` one cycle after the write that should or should not have cleared it. A machine stuck in `FL_SET_SEEN` turns a write of 0 that should be ignored into a clear. A machine that never reaches that state ignores a write of 0 that should clear the flag. The bench therefore compares `rd_data` after every write, read and pulse. It also runs the ordering cases: a write with no read before it, a second write after a read, a set event between the read and the write, and a set event in the same cycle as the write. A transmit-end machine with the wrong priority shows in the single cycle where a set pulse and a clear pulse coincide.

// File: rtl/sps_pkg.sv
package sps_pkg;
    localparam int REG_W   = 5;
    localparam int NUM_ERR = 2;
    // bit positions decoded by software
    localparam int B_FRM  = 4;
    localparam int B_PAR  = 3;
    localparam int B_TEND = 2;
    localparam int B_RMPB = 1;
    localparam int B_TMPB = 0;

    typedef enum logic [1:0] {
        FL_CLEAR      = 2'd0,
        FL_SET_UNSEEN = 2'd1,
        FL_SET_SEEN   = 2'd2
    } flag_st_e;

    typedef enum logic {
        TX_BUSY  = 1'b0,
        TX_ENDED = 1'b1
    } tend_st_e;
endpackage

// File: rtl/sps_flag_fsm.sv
module sps_flag_fsm
    import sps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic set_evt,
    input  logic rd_evt,
    input  logic wr_evt,
    input  logic wr_bit,
    output logic flag_q
);
    flag_st_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (standby) begin
            st_d = FL_CLEAR;
        end else if (set_evt) begin
            st_d = FL_SET_UNSEEN;           // set wins, marker dropped
        end else begin
            unique case (st_q)
                FL_CLEAR:      st_d = FL_CLEAR;
                FL_SET_UNSEEN: if (!wr_evt && rd_evt) st_d = FL_SET_SEEN;
                FL_SET_SEEN:   if (wr_evt) st_d = wr_bit ? FL_SET_UNSEEN : FL_CLEAR;
                default:       st_d = FL_CLEAR;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FL_CLEAR;
        else        st_q <= st_d;
    end

    always_comb flag_q = (st_q != FL_CLEAR);

    p_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> !flag_q);
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FL_SET_SEEN && wr_evt && !wr_bit && !set_evt && !standby) |=> !flag_q);
    p_no_clear_unseen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == FL_SET_UNSEEN && !standby) |=> flag_q);
    p_write_consumes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_evt && !standby) |=> (st_q != FL_SET_SEEN));
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_evt && !standby) |=> flag_q);
endmodule

// File: rtl/sps_tend_fsm.sv
module sps_tend_fsm
    import sps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic standby,
    input  logic tx_disable,
    input  logic tx_last_bit,
    input  logic tdr_empty,
    input  logic tdre_clear,
    input  logic dma_tdr_wr,
    output logic tend_q
);
    tend_st_e st_q, st_d;
    logic set_evt, clr_evt;

    always_comb begin
        set_evt = tx_disable || (tx_last_bit && tdr_empty);
        clr_evt = tdre_clear || dma_tdr_wr;
    end

    always_comb begin
        st_d = st_q;
        if (standby || set_evt) begin
            st_d = TX_ENDED;
        end else begin
            unique case (st_q)
                TX_ENDED: if (clr_evt) st_d = TX_BUSY;
                TX_BUSY:  st_d = TX_BUSY;
                default:  st_d = TX_ENDED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TX_ENDED;
        else        st_q <= st_d;
    end

    always_comb tend_q = (st_q == TX_ENDED);

    p_tend_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> tend_q);
    p_tend_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_disable || (tx_last_bit && tdr_empty)) |=> tend_q);
    p_tend_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !tx_disable && !(tx_last_bit && tdr_empty) && !standby) |=> !tend_q);
endmodule

// File: rtl/sps_mpb_regs.sv
module sps_mpb_regs (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_done,
    input  logic rx_mpb,
    input  logic wr_evt,
    input  logic wr_bit,
    output logic rmpb_q,
    output logic tmpb_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rmpb_q <= 1'b0;
            tmpb_q <= 1'b0;
        end else begin
            if (rx_done) rmpb_q <= rx_mpb;
            if (wr_evt)  tmpb_q <= wr_bit;
        end
    end

    p_rmpb_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> (rmpb_q == $past(rx_mpb)));
    p_rmpb_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_done |=> $stable(rmpb_q));
    p_tmpb_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |=> (tmpb_q == $past(wr_bit)));
endmodule

// File: rtl/ser_stat_reg.sv
module ser_stat_reg
    import sps_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             standby,
    input  logic             bus_rd,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] rd_data,
    input  logic             rx_frame_err,
    input  logic             rx_parity_err,
    input  logic             rx_done,
    input  logic             rx_mpb,
    input  logic             tx_disable,
    input  logic             tx_last_bit,
    input  logic             tdr_empty,
    input  logic             tdre_clear,
    input  logic             dma_tdr_wr,
    output logic             tx_mpb
);
    localparam int ERR_LO = B_PAR;

    logic [NUM_ERR-1:0] err_set, err_q;
    logic tend_q, rmpb_q, tmpb_q;

    always_comb err_set = {rx_frame_err, rx_parity_err};

    for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
        sps_flag_fsm u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .standby(standby),
            .set_evt(err_set[i]),
            .rd_evt (bus_rd),
            .wr_evt (bus_wr),
            .wr_bit (bus_wdata[ERR_LO+i]),
            .flag_q (err_q[i])
        );
    end

    sps_tend_fsm u_tend (
        .clk        (clk),
        .rst_n      (rst_n),
        .standby    (standby),
        .tx_disable (tx_disable),
        .tx_last_bit(tx_last_bit),
        .tdr_empty  (tdr_empty),
        .tdre_clear (tdre_clear),
        .dma_tdr_wr (dma_tdr_wr),
        .tend_q     (tend_q)
    );

    sps_mpb_regs u_mpb (
        .clk   (clk),
        .rst_n (rst_n),
        .rx_done(rx_done),
        .rx_mpb(rx_mpb),
        .wr_evt(bus_wr),
        .wr_bit(bus_wdata[B_TMPB]),
        .rmpb_q(rmpb_q),
        .tmpb_q(tmpb_q)
    );

    always_comb begin
        rd_data         = '0;
        rd_data[B_FRM]  = err_q[1];
        rd_data[B_PAR]  = err_q[0];
        rd_data[B_TEND] = tend_q;
        rd_data[B_RMPB] = rmpb_q;
        rd_data[B_TMPB] = tmpb_q;
        tx_mpb          = tmpb_q;
    end

    p_frm_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_err && !standby) |=> rd_data[B_FRM]);
    p_par_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_parity_err && !standby) |=> rd_data[B_PAR]);
    p_tmpb_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
        tx_mpb == rd_data[B_TMPB]);
endmodule

// File: tb/tb_ser_stat_reg.sv
module tb_ser_stat_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       standby = 0, bus_rd = 0, bus_wr = 0;
    logic [4:0] bus_wdata = '0;
    logic [4:0] rd_data;
    logic       rx_frame_err = 0, rx_parity_err = 0, rx_done = 0, rx_mpb = 0;
    logic       tx_disable = 0, tx_last_bit = 0, tdr_empty = 0, tdre_clear = 0, dma_tdr_wr = 0;
    logic       tx_mpb;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    typedef struct {
        string      tag;
        logic [4:0] exp;
    } item_t;
    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_stat_reg dut (
        .clk(clk), .rst_n(rst_n), .standby(standby),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .rx_frame_err(rx_frame_err), .rx_parity_err(rx_parity_err),
        .rx_done(rx_done), .rx_mpb(rx_mpb),
        .tx_disable(tx_disable), .tx_last_bit(tx_last_bit), .tdr_empty(tdr_empty),
        .tdre_clear(tdre_clear), .dma_tdr_wr(dma_tdr_wr), .tx_mpb(tx_mpb)
    );

    // monitor: compares at the falling edge, after the registers settled
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (rd_data !== it.exp || tx_mpb !== it.exp[0]) begin
                errors++;
                $display("FAIL %s: rd_data=%b tx_mpb=%b expected %b", it.tag, rd_data, tx_mpb, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
        standby = 0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
        rx_frame_err = 0; rx_parity_err = 0; rx_done = 0; rx_mpb = 0;
        tx_disable = 0; tx_last_bit = 0; tdre_clear = 0; dma_tdr_wr = 0;
    endtask

    task automatic expect_val(string tag, logic [4:0] exp);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic rd(); bus_rd = 1; tick(); endtask
    task automatic wr(logic [4:0] d); bus_wr = 1; bus_wdata = d; tick(); endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        expect_val("R1 reset value", 5'b00100);

        rx_frame_err = 1; tick();
        expect_val("R2 framing set", 5'b10100);

        wr(5'b00000);
        expect_val("R5 write0 without read", 5'b10100);

        rd();
        expect_val("R4 read keeps flag", 5'b10100);
        wr(5'b00000);
        expect_val("R4 framing cleared", 5'b00100);

        rx_parity_err = 1; tick();
        expect_val("R3 parity set", 5'b01100);
        wr(5'b11000);
        expect_val("R5 write1 no effect", 5'b01100);

        rd(); wr(5'b01000); wr(5'b00000);
        expect_val("R6 marker consumed", 5'b01100);

        rd(); rx_parity_err = 1; tick(); wr(5'b00000);
        expect_val("R7 set between read and write", 5'b01100);

        rd(); rx_parity_err = 1; bus_wr = 1; bus_wdata = 5'b00000; tick();
        expect_val("R8 set wins over clear", 5'b01100);

        rd(); wr(5'b00000);
        expect_val("R4 parity cleared", 5'b00100);

        dma_tdr_wr = 1; tick();
        expect_val("R10 dma clears tend", 5'b00000);

        tdr_empty = 0; tx_last_bit = 1; tick();
        expect_val("R9 last bit without tdre", 5'b00000);

        tdr_empty = 1; tx_last_bit = 1; tick();
        expect_val("R9 last bit with tdre", 5'b00100);

        tdre_clear = 1; tick();
        expect_val("R10 tdre clear", 5'b00000);

        tx_disable = 1; tick();
        expect_val("R9 tx disable", 5'b00100);

        tx_disable = 1; tdre_clear = 1; tick();
        expect_val("R10 set wins", 5'b00100);

        rx_done = 1; rx_mpb = 1; tick();
        expect_val("R11 rx mpb 1", 5'b00110);

        rx_mpb = 1; tick();
        expect_val("R11 no done keeps", 5'b00110);

        rx_done = 1; rx_mpb = 0; tick();
        expect_val("R11 rx mpb 0", 5'b00100);

        wr(5'b11111);
        expect_val("R12 write ones", 5'b00101);

        rd(); wr(5'b00000);
        expect_val("R12 tend not writable", 5'b00100);

        rx_frame_err = 1; rx_parity_err = 1; tick();
        dma_tdr_wr = 1; tick();
        expect_val("R1 before standby", 5'b11000);
        standby = 1; tick();
        expect_val("R1 standby", 5'b00100);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule